// File: doc/BRIEF.md
# Dimension-Order Mesh Route Unit

This unit is the route-computation stage for one input port of a two-dimensional mesh router. A packet header carries signed x and y offsets: the distance, in hops, from the current node to the destination, taken as destination minus current position. The unit picks one of five output ports: west, east, south, north or the local processor port. It also returns the offsets the packet will carry after the hop.

In the default mode the unit routes in strict dimension order. It reduces x to zero before it moves in y, so the route is deterministic. In west-first mode every westward hop is taken before any other. After that the unit reports a mask of all productive ports among east, north and south, and two congestion inputs choose between the x and y candidates. When the congestion inputs do not favour y, the x direction wins. A route therefore never turns into the west direction, which keeps the mesh free of deadlock while still leaving room to adapt.

Each header presented with `hdr_valid` produces its decision on the next clock edge. The outputs keep their values until the next header arrives.

Top module: `mesh_route_unit`

## Requirements
- R1: After reset, `rt_valid`, `rt_port` and `rt_cand` are all zero.
- R2: Offsets are 4-bit two's complement. `rt_port` is one-hot with bit 0 = west, bit 1 = east, bit 2 = south, bit 3 = north and bit 4 = local. In strict mode a negative x selects west and a positive x selects east, whatever y is.
- R3: In strict mode, when x is zero, a negative y selects south and a positive y selects north.
- R4: When both offsets are zero, the local port (bit 4) is selected in either mode, and the outgoing offsets are both zero.
- R5: The outgoing offsets change only in the chosen dimension, by one step toward zero: east decrements x, west increments x, north decrements y and south increments y.
- R6: A header accepted on a clock edge sets `rt_valid` for exactly the following cycle. While `hdr_valid` is low, `rt_port`, `rt_cand`, `out_dx` and `out_dy` hold their values.
- R7: In west-first mode a negative x selects west, and `rt_cand` is west only.
- R8: In west-first mode with x not negative, `rt_cand` marks every productive port among east (x>0), south (y<0) and north (y>0). It marks local only when both offsets are zero.
- R9: In west-first mode, when both x and y are productive, the y port is chosen only if `cong_x` is 1 and `cong_y` is 0. Otherwise east is chosen. The chosen port is always inside `rt_cand`.
- R10: In strict mode `rt_cand` equals `rt_port`, and the congestion inputs have no effect.
- R11: Feeding the outgoing offsets back hop by hop from any start in -7..+7 reaches the local port in exactly |x|+|y| hops, with no west hop after a non-west hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dx | input | 4 | Relative x offset, two's complement |
| hdr_dy | input | 4 | Relative y offset, two's complement |
| west_first | input | 1 | 1 selects west-first adaptive mode |
| cong_x | input | 1 | x output congested |
| cong_y | input | 1 | y output congested |
| rt_valid | output | 1 | Decision valid |
| rt_port | output | 5 | One-hot chosen port {L,N,S,E,W} |
| rt_cand | output | 5 | Productive candidate ports |
| out_dx | output | 4 | x offset after the hop |
| out_dy | output | 4 | y offset after the hop |

## Verification
The behaviour that is hardest to reach from the ports is a long adaptive route that bends between x and y several times without ever turning back into west. A single header shows only one hop. The bench therefore feeds each decision's outgoing offsets back in as the next header, for every start pair in -7..+7 and in both modes. On each hop it varies the congestion inputs, so that adaptive routes alternate between their x and y candidates, and it tracks the hop count and the turn history until the local port appears.

// File: rtl/mesh_route_unit.sv
module mesh_route_unit #(
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_valid,
  input  logic [OW-1:0] hdr_dx,
  input  logic [OW-1:0] hdr_dy,
  input  logic          west_first,
  input  logic          cong_x,
  input  logic          cong_y,
  output logic          rt_valid,
  output logic [4:0]    rt_port,
  output logic [4:0]    rt_cand,
  output logic [OW-1:0] out_dx,
  output logic [OW-1:0] out_dy
);
  localparam logic [4:0] P_W = 5'b00001;
  localparam logic [4:0] P_E = 5'b00010;
  localparam logic [4:0] P_S = 5'b00100;
  localparam logic [4:0] P_N = 5'b01000;
  localparam logic [4:0] P_L = 5'b10000;

  logic xneg, xpos, yneg, ypos;
  logic [4:0] xy_sel, sel, cand;
  logic [OW-1:0] nx, ny;

  assign xneg = hdr_dx[OW-1];
  assign xpos = !hdr_dx[OW-1] && (|hdr_dx);
  assign yneg = hdr_dy[OW-1];
  assign ypos = !hdr_dy[OW-1] && (|hdr_dy);

  assign xy_sel = xneg ? P_W : xpos ? P_E : yneg ? P_S : ypos ? P_N : P_L;

  always_comb begin
    sel  = xy_sel;
    cand = xy_sel;
    if (west_first && !xneg) begin
      cand = {!xpos && !yneg && !ypos, ypos, yneg, xpos, 1'b0};
      if (xpos && (ypos || yneg) && cong_x && !cong_y)
        sel = ypos ? P_N : P_S;
    end
  end

  always_comb begin
    nx = hdr_dx;
    ny = hdr_dy;
    unique case (sel)
      P_W:     nx = hdr_dx + 1'b1;
      P_E:     nx = hdr_dx - 1'b1;
      P_S:     ny = hdr_dy + 1'b1;
      P_N:     ny = hdr_dy - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_valid <= 1'b0;
      rt_port  <= '0;
      rt_cand  <= '0;
      out_dx   <= '0;
      out_dy   <= '0;
    end else begin
      rt_valid <= hdr_valid;
      if (hdr_valid) begin
        rt_port <= sel;
        rt_cand <= cand;
        out_dx  <= nx;
        out_dy  <= ny;
      end
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> $countones(rt_port) == 1);

  p_in_cand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> (rt_port & ~rt_cand) == 5'b0);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !rt_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> $stable(rt_port) && $stable(out_dx) && $stable(out_dy));

  p_west_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_dx[OW-1] |=> rt_port == P_W && rt_cand == P_W);

  p_east_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_dx[OW-1] && (|hdr_dx) && !west_first
    |=> out_dx == $past(hdr_dx) - 1'b1 && out_dy == $past(hdr_dy));

  p_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_dx == '0 && hdr_dy == '0
    |=> rt_port == P_L && out_dx == '0 && out_dy == '0);
endmodule

// File: tb/mesh_route_unit_test.sv
module mesh_route_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [3:0] hdr_dx = '0, hdr_dy = '0;
  logic west_first = 1'b0, cong_x = 1'b0, cong_y = 1'b0;
  logic rt_valid;
  logic [4:0] rt_port, rt_cand;
  logic [3:0] out_dx, out_dy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mesh_route_unit uut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dx(hdr_dx), .hdr_dy(hdr_dy),
    .west_first(west_first), .cong_x(cong_x), .cong_y(cong_y), .rt_valid(rt_valid),
    .rt_port(rt_port), .rt_cand(rt_cand), .out_dx(out_dx), .out_dy(out_dy));

  // {dx[20:17], dy[16:13], wf[12], cx[11], cy[10], port[9:5], cand[4:0]}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {4'hD, 4'h2, 3'b000, 5'b00001, 5'b00001},  // R2 west
    {4'h5, 4'hF, 3'b000, 5'b00010, 5'b00010},  // R2 east
    {4'h0, 4'hC, 3'b000, 5'b00100, 5'b00100},  // R3 south
    {4'h0, 4'h6, 3'b000, 5'b01000, 5'b01000},  // R3 north
    {4'h0, 4'h0, 3'b000, 5'b10000, 5'b10000},  // R4 local
    {4'h8, 4'h7, 3'b100, 5'b00001, 5'b00001},  // R7 west first
    {4'h3, 4'h2, 3'b100, 5'b00010, 5'b01010},  // R8 R9 tie to x
    {4'h3, 4'h2, 3'b110, 5'b01000, 5'b01010},  // R9 x congested
    {4'h3, 4'hE, 3'b111, 5'b00010, 5'b00110},  // R9 both congested
    {4'h0, 4'hB, 3'b110, 5'b00100, 5'b00100},  // R8 y only
    {4'h4, 4'h0, 3'b110, 5'b00010, 5'b00010},  // R8 x only
    {4'h0, 4'h0, 3'b100, 5'b10000, 5'b10000},  // R4 local west-first
    {4'h7, 4'h9, 3'b010, 5'b00010, 5'b00010}   // R10 congestion ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] dx, input logic [3:0] dy,
                      input logic wf, input logic cx, input logic cy);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dx = dx; hdr_dy = dy;
    west_first = wf; cong_x = cx; cong_y = cy;
    @(posedge clk); #1;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(rt_valid == 1'b0 && rt_port == 5'b0 && rt_cand == 5'b0, "R1 reset", rt_port, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      @(negedge clk);
      hdr_valid = 1'b1; hdr_dx = v[20:17]; hdr_dy = v[16:13];
      west_first = v[12]; cong_x = v[11]; cong_y = v[10];
      @(posedge clk); #1;
      check(rt_valid, "R6 valid after header", rt_valid, 1);
      check(rt_port == v[9:5], "R2/R3/R4/R7/R9 table port", rt_port, v[9:5]);
      check(rt_cand == v[4:0], "R8/R10 table cand", rt_cand, v[4:0]);
      @(negedge clk); hdr_valid = 1'b0;
    end

    // R6 hold: change inputs without valid
    send(4'h2, 4'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); hdr_dx = 4'hA; hdr_dy = 4'h5; west_first = 1'b1;
    @(posedge clk); #1;
    check(rt_valid == 1'b0, "R6 single-cycle valid", rt_valid, 0);
    @(posedge clk); #1;
    check(rt_port == 5'b00010 && out_dx == 4'h1 && out_dy == 4'h0, "R6 hold", rt_port, 2);

    // R11 / R5 exhaustive walks
    for (int mode = 0; mode < 2; mode++) begin
      for (int sx = -7; sx <= 7; sx++) begin
        for (int sy = -7; sy <= 7; sy++) begin
          int x, y, hops, step;
          bit left_west, done;
          x = sx; y = sy; hops = 0; step = 0; left_west = 0; done = 0;
          while (!done && step < 20) begin
            logic cx, cy;
            logic [4:0] ep;
            int ex, ey;
            cx = ((step + sx) & 1) != 0;
            cy = ((step + sy) % 3) == 0;
            if (x < 0) ep = 5'b00001;
            else if (x > 0 && (mode == 0 || y == 0 || !(cx && !cy))) ep = 5'b00010;
            else if (y < 0) ep = 5'b00100;
            else if (y > 0) ep = 5'b01000;
            else ep = 5'b10000;
            ex = x + (ep == 5'b00001 ? 1 : 0) - (ep == 5'b00010 ? 1 : 0);
            ey = y + (ep == 5'b00100 ? 1 : 0) - (ep == 5'b01000 ? 1 : 0);
            @(negedge clk);
            hdr_valid = 1'b1; hdr_dx = 4'(x); hdr_dy = 4'(y);
            west_first = mode[0]; cong_x = cx; cong_y = cy;
            @(posedge clk); #1;
            check(rt_port == ep, "R11 walk port", rt_port, ep);
            check($signed(out_dx) == ex && $signed(out_dy) == ey, "R5 offset step",
                  $signed(out_dx), ex);
            if (rt_port == 5'b00001)
              check(!left_west, "R11 turn into west", 1, 0);
            else
              left_west = 1;
            if (rt_port == 5'b10000) done = 1;
            else hops++;
            x = $signed(out_dx); y = $signed(out_dy);
            step++;
          end
          check(done && hops == ((sx < 0 ? -sx : sx) + (sy < 0 ? -sy : sy)),
                "R11 hop count", hops, (sx < 0 ? -sx : sx) + (sy < 0 ? -sy : sy));
        end
      end
    end
    @(negedge clk); hdr_valid = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule